// File: doc/BRIEF.md
# Daisy-chain DAC frame sequencer

This block sits on the host side of a serial link that feeds a chain of identical 16-bit DAC devices. The devices share one serial clock and one active-low frame strobe. Each device passes the bits it has already received on to the next device, so one data line from the host reaches the whole chain. The host loads one 16-bit frame per device through a parallel valid/ready port. The first frame loaded is for device 0, the device wired next to the host. Once all frames are held, a start request sends them in one continuous strobe-low window. The frame for the farthest device goes first and each frame is sent most significant bit first. The strobe then rises, and at that edge every device in the chain commits its frame together.

The controller has three states. In IDLE the serial clock sits high and the strobe is deasserted. The IDLE→SHIFT transition happens on a start request once every frame is held. SHIFT lasts 16·NUM_DEV serial clock periods. Each period is a high half followed by a low half, and each half lasts HALF_DIV system clocks. The SHIFT→HOLD transition happens at the rising serial clock edge that closes the last period: the strobe rises there and a one-cycle done pulse is issued. HOLD keeps the strobe high for HOLD_PERIODS serial periods. The HOLD→IDLE transition happens once that time has elapsed. The frame store is then empty and new frames must be loaded.

Top module: `dcs_chain_seq`

## Requirements
- R1: After reset, ser_clk and ser_frame_n are 1, ser_data, busy and done are 0, and load_ready is 1.
- R2: load_ready is high only in IDLE with fewer than NUM_DEV frames held. Each accepted frame goes to the next device index, starting at 0. A load_valid while the store is full is ignored.
- R3: A start request is taken only in IDLE with all NUM_DEV frames held. Otherwise it is ignored: busy stays 0 and ser_frame_n stays 1.
- R4: A start request while busy (SHIFT or HOLD) is ignored and does not open a second window.
- R5: ser_frame_n stays low with no gap for exactly 16·NUM_DEV serial clock periods. A period is 2·HALF_DIV system clocks.
- R6: The bit stream goes out in descending device index order (last loaded frame first), and each frame goes out bit 15 first.
- R7: ser_clk is high whenever ser_frame_n is high. ser_data changes only together with a rising ser_clk edge and is held stable while ser_clk is low.
- R8: done is high for exactly one system clock, in the first cycle in which ser_frame_n is high again.
- R9: After ser_frame_n rises it stays high, with busy set, for HOLD_PERIODS serial periods (2 by default, 4·HALF_DIV clocks) before another window can start.
- R10: The serial clock rate SYS_MHZ/(2·HALF_DIV) does not exceed 40 MHz.
- R11: After a transaction the store counts as empty: load_ready returns to 1, and a start request without NUM_DEV new frames is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_valid | input | 1 | Frame offered on load_data |
| load_data | input | FRAME_W | Frame for the next device index |
| load_ready | output | 1 | Store can accept a frame |
| start | input | 1 | Request to send the held frames |
| busy | output | 1 | Controller in SHIFT or HOLD |
| done | output | 1 | One-cycle pulse when the strobe rises |
| ser_clk | output | 1 | Serial clock shared by all devices, idles high |
| ser_frame_n | output | 1 | Shared active-low frame strobe; its rise commits all frames |
| ser_data | output | 1 | Serial data to the first device in the chain |

## Verification
The bench builds the block with NUM_DEV=3, FRAME_W=16 and HALF_DIV=3 on a 200 MHz clock. This gives 48-bit windows at a 33.3 MHz serial clock. With three devices the reverse ordering is not symmetric: a swapped first and last frame, or a wrong middle frame, shows up as a wrong stream. An odd half period separates an off-by-one in the divider from one in the bit counter. A short HOLD of 12 cycles lets start requests land inside it. Partial loads, starts while busy, loads into a full store and back-to-back random transactions are all reached.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2
    } dcs_state_t;
endpackage

// File: rtl/dcs_half_timer.sv
// Counts HALF_DIV system clocks per serial-clock half period while run is high.
module dcs_half_timer #(
    parameter int HALF_DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/dcs_frame_store.sv
// One register per device; the chain vector places the highest index in the top bits.
module dcs_frame_store #(
    parameter int NUM_DEV = 3,
    parameter int FRAME_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [FRAME_W-1:0]           wr_data,
    input  logic                         clear,
    output logic                         full,
    output logic [NUM_DEV*FRAME_W-1:0]   chain
);
    localparam int CNT_W = $clog2(NUM_DEV + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NUM_DEV);

    logic [CNT_W-1:0]   cnt_q;
    logic [FRAME_W-1:0] mem_q [NUM_DEV];

    assign full = (cnt_q == FULL_CNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (wr_en && !full)
            cnt_q <= cnt_q + 1'b1;
    end

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem_q[g] <= '0;
            else if (wr_en && !full && cnt_q == CNT_W'(g))
                mem_q[g] <= wr_data;
        end
        assign chain[(g+1)*FRAME_W-1 -: FRAME_W] = mem_q[g];
    end
endmodule

// File: rtl/dcs_shifter.sv
// Parallel-load, shift-left register; the top bit drives the serial line.
module dcs_shifter #(
    parameter int WIDTH = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] par_in,
    input  logic             shift,
    output logic             bit_out
);
    logic [WIDTH-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr_q <= '0;
        else if (load)
            sr_q <= par_in;
        else if (shift)
            sr_q <= {sr_q[WIDTH-2:0], 1'b0};
    end

    assign bit_out = sr_q[WIDTH-1];
endmodule

// File: rtl/dcs_chain_seq.sv
module dcs_chain_seq #(
    parameter int NUM_DEV      = 3,
    parameter int FRAME_W      = 16,
    parameter int HALF_DIV     = 3,
    parameter int HOLD_PERIODS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_valid,
    input  logic [FRAME_W-1:0] load_data,
    output logic               load_ready,
    input  logic               start,
    output logic               busy,
    output logic               done,
    output logic               ser_clk,
    output logic               ser_frame_n,
    output logic               ser_data
);
    import dcs_pkg::*;

    localparam int TOTAL      = NUM_DEV * FRAME_W;
    localparam int BIT_W      = (TOTAL > 1) ? $clog2(TOTAL) : 1;
    localparam int HOLD_TICKS = 2 * HOLD_PERIODS;
    localparam int HOLD_W     = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(TOTAL - 1);
    localparam logic [HOLD_W-1:0] LAST_HOLD = HOLD_W'(HOLD_TICKS - 1);

    dcs_state_t state_q, state_nx;

    logic                     tick;
    logic                     full;
    logic [TOTAL-1:0]         chain;
    logic                     start_ok;
    logic                     shift_en;
    logic                     last_bit;
    logic                     sclk_q, frame_q, done_q, phase_low_q;
    logic [BIT_W-1:0]         bit_idx_q;
    logic [HOLD_W-1:0]        hold_q;

    assign busy       = (state_q != ST_IDLE);
    assign load_ready = (state_q == ST_IDLE) && !full;
    assign start_ok   = start && (state_q == ST_IDLE) && full;
    assign last_bit   = (bit_idx_q == LAST_BIT);
    assign shift_en   = (state_q == ST_SHIFT) && tick && phase_low_q && !last_bit;

    dcs_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    dcs_frame_store #(.NUM_DEV(NUM_DEV), .FRAME_W(FRAME_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (load_valid && load_ready),
        .wr_data (load_data),
        .clear   (start_ok),
        .full    (full),
        .chain   (chain)
    );

    dcs_shifter #(.WIDTH(TOTAL)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start_ok),
        .par_in  (chain),
        .shift   (shift_en),
        .bit_out (ser_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_ok) state_nx = ST_SHIFT;
            ST_SHIFT: if (tick && phase_low_q && last_bit) state_nx = ST_HOLD;
            ST_HOLD:  if (tick && hold_q == LAST_HOLD) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Registered outputs and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q      <= 1'b1;
            frame_q     <= 1'b1;
            done_q      <= 1'b0;
            phase_low_q <= 1'b0;
            bit_idx_q   <= '0;
            hold_q      <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_ok) begin
                        frame_q     <= 1'b0;
                        sclk_q      <= 1'b1;
                        phase_low_q <= 1'b0;
                        bit_idx_q   <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!phase_low_q) begin
                            sclk_q      <= 1'b0;
                            phase_low_q <= 1'b1;
                        end else begin
                            sclk_q      <= 1'b1;
                            phase_low_q <= 1'b0;
                            if (last_bit) begin
                                frame_q <= 1'b1;
                                done_q  <= 1'b1;
                                hold_q  <= '0;
                            end else begin
                                bit_idx_q <= bit_idx_q + 1'b1;
                            end
                        end
                    end
                end
                ST_HOLD: begin
                    if (tick)
                        hold_q <= hold_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign ser_clk     = sclk_q;
    assign ser_frame_n = frame_q;
    assign done        = done_q;
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
    parameter int NUM_DEV      = 3,
    parameter int FRAME_W      = 16,
    parameter int HALF_DIV     = 3,
    parameter int HOLD_PERIODS = 2
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic load_ready,
    input logic ser_clk,
    input logic ser_frame_n,
    input logic ser_data
);
    localparam int TOTAL   = NUM_DEV * FRAME_W;
    localparam int CW      = $clog2(TOTAL + 1) + 1;
    localparam int GAP_MIN = 2 * HOLD_PERIODS * HALF_DIV;
    localparam int GW      = $clog2(GAP_MIN + 1) + 1;

    logic          prev_sclk, prev_frame;
    logic [CW-1:0] win_falls;
    logic [GW-1:0] gap_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_sclk  <= 1'b1;
            prev_frame <= 1'b1;
            win_falls  <= '0;
            gap_cnt    <= GW'(GAP_MIN);
        end else begin
            prev_sclk  <= ser_clk;
            prev_frame <= ser_frame_n;
            if (prev_frame && !ser_frame_n)
                win_falls <= '0;
            else if (prev_sclk && !ser_clk)
                win_falls <= win_falls + 1'b1;
            if (!ser_frame_n)
                gap_cnt <= '0;
            else if (gap_cnt < GW'(GAP_MIN))
                gap_cnt <= gap_cnt + 1'b1;
        end
    end

    assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ser_frame_n |-> ser_clk);

    assert_data_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_clk && $past(!ser_clk)) |-> $stable(ser_data));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_at_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!prev_frame && ser_frame_n) |-> done);

    assert_window_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!prev_frame && ser_frame_n) |-> (win_falls == CW'(TOTAL)));

    assert_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_frame && !ser_frame_n) |-> (gap_cnt >= GW'(GAP_MIN)));

    assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_ready |-> !busy);

    assert_start_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_frame && !ser_frame_n) |-> $past(!busy && start));
endmodule

bind dcs_chain_seq dcs_checker #(
    .NUM_DEV(NUM_DEV), .FRAME_W(FRAME_W),
    .HALF_DIV(HALF_DIV), .HOLD_PERIODS(HOLD_PERIODS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .load_ready(load_ready), .ser_clk(ser_clk), .ser_frame_n(ser_frame_n),
    .ser_data(ser_data)
);

// File: tb/tb_dcs_chain_seq.sv
`timescale 1ns/1ps
module tb_dcs_chain_seq;
    localparam int N   = 3;
    localparam int FW  = 16;
    localparam int H   = 3;
    localparam int HP  = 2;
    localparam int TOT = N * FW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_valid = 1'b0;
    logic [FW-1:0] load_data = '0;
    logic          start = 1'b0;
    logic          load_ready, busy, done, ser_clk, ser_frame_n, ser_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [FW-1:0] frames [N];

    always #2.5 clk = ~clk;

    dcs_chain_seq #(.NUM_DEV(N), .FRAME_W(FW), .HALF_DIV(H), .HOLD_PERIODS(HP)) dut (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_data(load_data),
        .load_ready(load_ready), .start(start), .busy(busy), .done(done),
        .ser_clk(ser_clk), .ser_frame_n(ser_frame_n), .ser_data(ser_data)
    );

    // Monitor, sampled on the falling system clock edge
    logic [TOT-1:0] cap = '0;
    int nbits = 0, falls = 0, done_cnt = 0, dw = 0, dwmax = 0;
    int low_run = 0, last_low = 0, hold_run = 0, last_hold = 0;
    int viol_idle = 0, viol_data = 0;
    logic p_sclk = 1'b1, p_frame = 1'b1, p_busy = 1'b0, p_done = 1'b0, p_data = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_sclk && !ser_clk) begin
                cap = {cap[TOT-2:0], ser_data};
                nbits++;
            end
            if (!ser_clk && !p_sclk && ser_data != p_data) viol_data++;
            if (ser_frame_n && !ser_clk) viol_idle++;
            if (!ser_frame_n) low_run++;
            if (!p_frame && ser_frame_n) begin last_low = low_run; low_run = 0; end
            if (p_frame && !ser_frame_n) falls++;
            if (busy && ser_frame_n) hold_run++;
            if (p_busy && !busy) begin last_hold = hold_run; hold_run = 0; end
            if (done) begin
                done_cnt++;
                dw = p_done ? dw + 1 : 1;
                if (dw > dwmax) dwmax = dw;
            end
        end
        p_sclk = ser_clk; p_frame = ser_frame_n; p_busy = busy;
        p_done = done; p_data = ser_data;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [TOT-1:0] exp_stream();
        logic [TOT-1:0] r;
        for (int i = 0; i < N; i++) r[(i+1)*FW-1 -: FW] = frames[i];
        return r;
    endfunction

    task automatic load_one(input logic [FW-1:0] d);
        @(negedge clk);
        load_valid = 1'b1;
        load_data  = d;
        @(negedge clk);
        load_valid = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic load_from(input int first);
        for (int i = first; i < N; i++) load_one(frames[i]);
        chk(load_ready == 1'b0, "R2 ready low when full", 64'(load_ready), 64'd0);
    endtask

    task automatic do_txn(input bit mid);
        int f0, b0, d0;
        f0 = falls; b0 = nbits; d0 = done_cnt;
        pulse_start();
        if (mid) begin
            repeat (20) @(negedge clk);
            pulse_start();
        end
        do @(negedge clk); while (!done);
        if (mid) pulse_start();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(nbits - b0 == TOT, "R5 sclk falls in window", 64'(nbits - b0), 64'(TOT));
        chk(last_low == TOT * 2 * H, "R5 window length", 64'(last_low), 64'(TOT * 2 * H));
        chk(cap == exp_stream(), "R6 stream order", 64'(cap), 64'(exp_stream()));
        chk(falls - f0 == 1, mid ? "R4 single window" : "R3 single window", 64'(falls - f0), 64'd1);
        chk(done_cnt - d0 == 1 && dwmax == 1, "R8 done pulse", 64'(done_cnt - d0), 64'd1);
        chk(last_hold == 2 * HP * H, "R9 hold length", 64'(last_hold), 64'(2 * HP * H));
        chk(last_low >= TOT * 5, "R10 sclk <= 40 MHz", 64'(last_low), 64'(TOT * 5));
        chk(load_ready == 1'b1, "R11 store empty", 64'(load_ready), 64'd1);
        if (mid) begin
            repeat (5) @(negedge clk);
            chk(busy == 1'b0 && falls - f0 == 1, "R4 late start ignored", 64'(busy), 64'd0);
        end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R5 watchdog actual=hung expected=complete");
            finish_run();
        end
    end

    initial begin
        int f0;
        void'($urandom(32'd20250822));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ser_clk && ser_frame_n && !ser_data, "R1 serial idle", {61'd0, ser_clk, ser_frame_n, ser_data}, 64'b110);
        chk(!busy && !done && load_ready, "R1 handshake idle", {61'd0, busy, done, load_ready}, 64'b001);

        // Directed: asymmetric frames
        frames[0] = 16'h8001; frames[1] = 16'h7FFE; frames[2] = 16'hC35A;
        load_from(0);
        do_txn(1'b0);

        // R11 / R3: start with empty store ignored
        f0 = falls;
        pulse_start();
        repeat (10) @(negedge clk);
        chk(!busy && ser_frame_n && falls == f0, "R11 empty start ignored", 64'(busy), 64'd0);

        // R3: partial load, start ignored; then complete and junk load ignored (R2)
        frames[0] = 16'h1234; frames[1] = 16'hABCD; frames[2] = 16'h0F0F;
        load_one(frames[0]);
        pulse_start();
        repeat (10) @(negedge clk);
        chk(!busy && ser_frame_n && falls == f0, "R3 partial start ignored", 64'(busy), 64'd0);
        load_from(1);
        load_one(16'hDEAD);
        do_txn(1'b0);

        // R4: starts during SHIFT and HOLD
        frames[0] = 16'hFFFF; frames[1] = 16'h0000; frames[2] = 16'h5555;
        load_from(0);
        do_txn(1'b1);

        // Random transactions
        for (int t = 0; t < 8; t++) begin
            for (int i = 0; i < N; i++) frames[i] = FW'($urandom);
            load_from(0);
            do_txn(t[0]);
        end

        chk(viol_idle == 0, "R7 sclk high while strobe high", 64'(viol_idle), 64'd0);
        chk(viol_data == 0, "R7 data stable while sclk low", 64'(viol_data), 64'd0);
        finish_run();
    end
endmodule